// File: doc/BRIEF.md
# Eight-Byte Display Latch with Latch-Copy Writes

This block holds the read latches that sit between display memory and the graphics controller. Every memory read captures the returned bytes into the latch. A later host write can put them back in one cycle. A single control bit widens the latch from one byte per plane (four bytes) to eight bytes. The wide setting takes effect only while the times-eight (packed-pixel) addressing mode is also selected. In the wide setting a single latch-copy write moves eight pixels, 64 bits, back into memory. Without the wide setting it moves four.

The same latch feeds two more functions. A color-compare result gives one bit per latched pixel, matched against an eight-bit compare color under an eight-bit don't-care mask. A pattern-fill write takes one host bit per pixel and expands it to a foreground or background color. Each of the two colors is gated by its own enable. A pass-through write mode places the host byte, or the eight-bit set/reset value, into every byte lane. Byte enables come from the plane map mask. In the wide setting that mask is repeated across both four-byte halves.

Top module: `ext_latch_wm1`

## Requirements
- R1: A cycle with `mem_rd_valid` high loads latch bytes 0..3 from `mem_rd_data`. Bytes 4..7 load only when the wide setting is in effect. Otherwise they keep their previous value. Byte k is bits 8k+7..8k. With no read, the latch holds. After reset the latch is all zero.
- R2: The wide setting is in effect only when both `wide_en` and `x8_addr` are high. Any other combination behaves exactly as the four-byte setting.
- R3: A cycle with `host_wr` high produces `mem_wr_valid`, `mem_wr_data` and `mem_wr_be` on the following clock edge. A cycle without it leaves `mem_wr_valid` low and `mem_wr_be` zero on the next edge.
- R4: Write mode 1 (`wr_mode` = 01) copies the whole latch into `mem_wr_data`. The host byte has no effect. If a read happens in the same cycle, the copy uses the latch contents from before that read.
- R5: Write modes 0 (00) and 3 (11) put `sr_value` in every byte lane when `sr_en` is high, and `host_data` otherwise.
- R6: Write mode 2 (10) is pattern fill. For byte k, bit k of `host_data` selects `fg_color` when it is 1 and `bg_color` when it is 0. The byte is enabled only if the matching `fg_en` or `bg_en` is high.
- R7: `rd_cmp` bit k is 1 exactly when `((latch byte k XOR cmp_color) AND cmp_care)` is zero. It follows the latch and the compare inputs without delay.
- R8: Byte k's enable is `map_mask[k mod 4]`, further gated by R6 in fill mode. When the wide setting is not in effect, `mem_wr_be[7:4]` and `rd_cmp[7:4]` are zero.
- R9: After reset, `mem_wr_valid`, `mem_wr_data` and `mem_wr_be` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_en | input | 1 | Request for the eight-byte latch |
| x8_addr | input | 1 | Times-eight packed addressing selected |
| mem_rd_valid | input | 1 | Memory read data present this cycle |
| mem_rd_data | input | 64 | Memory read data, byte k in bits 8k+7..8k |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 8 | Host write byte, also pixel bits in fill mode |
| wr_mode | input | 2 | 00 pass, 01 latch copy, 10 pattern fill, 11 pass |
| map_mask | input | 4 | Plane enable mask |
| sr_en | input | 1 | Use set/reset value in pass mode |
| sr_value | input | 8 | Set/reset value |
| cmp_color | input | 8 | Color compare value |
| cmp_care | input | 8 | Compare mask, 1 means bit is compared |
| fg_color | input | 8 | Fill foreground color |
| bg_color | input | 8 | Fill background color |
| fg_en | input | 1 | Foreground pixels written |
| bg_en | input | 1 | Background pixels written |
| mem_wr_valid | output | 1 | Memory write issued |
| mem_wr_data | output | 64 | Memory write data |
| mem_wr_be | output | 8 | Memory write byte enables |
| rd_cmp | output | 8 | Color compare result, one bit per pixel |

## Verification
The bench builds the block with its defaults: four planes of eight-bit bytes, an eight-byte wide latch and an eight-bit host byte. At that size every fill pattern can be swept against all four wide/addressing combinations and every enable pair. Every compare mask value can be swept over fixed latch contents. The pass mode is swept over all host bytes with set/reset on and off. Latch-copy writes are checked in both widths, with a read landing in the same cycle, and against stale upper bytes left over from narrow reads.

// File: rtl/ext_latch_pkg.sv
// Package: shared write-mode encoding for the extended display latch.
// Assumes a two-bit mode field driven by the graphics controller.
package ext_latch_pkg;
    typedef enum logic [1:0] {
        WM_PASS = 2'b00,
        WM_COPY = 2'b01,
        WM_FILL = 2'b10,
        WM_ALT  = 2'b11
    } wmode_e;
endpackage

// File: rtl/elw_latch_bank.sv
// Latch bank: captures memory read bytes. The low half (one byte per
// plane) always loads on a read. The high half loads only in the wide
// setting and otherwise holds. Assumes mem data arrives with its valid.
module elw_latch_bank #(
    parameter int PLANES = 4,
    parameter int BW     = 8,
    localparam int WB    = 2 * PLANES,
    localparam int LW    = WB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          rd_valid,
    input  logic [LW-1:0] rd_data,
    output logic [LW-1:0] latch_q
);
    for (genvar k = 0; k < WB; k++) begin : g_byte
        localparam bit HIGH = (k >= PLANES);
        logic load;
        // decide whether this byte lane captures on the current read
        always_comb load = rd_valid && (!HIGH || wide);
        // hold or capture one latch byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q[k*BW +: BW] <= '0;
            else if (load)
                latch_q[k*BW +: BW] <= rd_data[k*BW +: BW];
        end
    end
endmodule

// File: rtl/elw_compare.sv
// Color compare: one result bit per latched pixel. The bit is set when the
// byte equals the compare color on every bit the care mask selects.
// High-half bits read zero outside the wide setting.
module elw_compare #(
    parameter int PLANES = 4,
    parameter int BW     = 8,
    localparam int WB    = 2 * PLANES,
    localparam int LW    = WB * BW
) (
    input  logic          wide,
    input  logic [LW-1:0] latch_q,
    input  logic [BW-1:0] cmp_color,
    input  logic [BW-1:0] cmp_care,
    output logic [WB-1:0] match
);
    for (genvar k = 0; k < WB; k++) begin : g_pix
        localparam bit HIGH = (k >= PLANES);
        // masked equality for one pixel, gated for the high half
        always_comb
            match[k] = (((latch_q[k*BW +: BW] ^ cmp_color) & cmp_care) == '0)
                       && (!HIGH || wide);
    end
endmodule

// File: rtl/elw_write_path.sv
// Write path: forms per-lane write data and enables for the selected mode
// and registers them one cycle after the host strobe. Assumes host_data
// has at least as many bits as there are wide-latch pixels for fill mode.
module elw_write_path
    import ext_latch_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int BW     = 8,
    localparam int WB    = 2 * PLANES,
    localparam int LW    = WB * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              host_wr,
    input  logic [BW-1:0]     host_data,
    input  wmode_e            mode,
    input  logic [PLANES-1:0] map_mask,
    input  logic              sr_en,
    input  logic [BW-1:0]     sr_value,
    input  logic [BW-1:0]     fg_color,
    input  logic [BW-1:0]     bg_color,
    input  logic              fg_en,
    input  logic              bg_en,
    input  logic [LW-1:0]     latch_q,
    output logic              wr_valid,
    output logic [LW-1:0]     wr_data,
    output logic [WB-1:0]     wr_be
);
    logic [LW-1:0] nxt_data;
    logic [WB-1:0] nxt_be;
    logic [BW-1:0] pass_byte;

    // pick the byte used by the pass-through modes
    always_comb pass_byte = sr_en ? sr_value : host_data;

    for (genvar k = 0; k < WB; k++) begin : g_lane
        localparam bit HIGH  = (k >= PLANES);
        localparam int PLANE = k % PLANES;
        localparam int PBIT  = k % BW;
        logic lane_on;
        logic pix;
        // plane enable for this lane, dropped for the high half when narrow
        always_comb lane_on = map_mask[PLANE] && (!HIGH || wide);
        // pixel bit that steers this lane during fill
        always_comb pix = host_data[PBIT];
        // lane data and enable for the current mode
        always_comb begin
            unique case (mode)
                WM_COPY: begin
                    nxt_data[k*BW +: BW] = latch_q[k*BW +: BW];
                    nxt_be[k]            = lane_on;
                end
                WM_FILL: begin
                    nxt_data[k*BW +: BW] = pix ? fg_color : bg_color;
                    nxt_be[k]            = lane_on && (pix ? fg_en : bg_en);
                end
                default: begin
                    nxt_data[k*BW +: BW] = pass_byte;
                    nxt_be[k]            = lane_on;
                end
            endcase
        end
    end

    // register the memory write one cycle after the host strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_be    <= '0;
        end else begin
            wr_valid <= host_wr;
            wr_be    <= host_wr ? nxt_be : '0;
            if (host_wr)
                wr_data <= nxt_data;
        end
    end
endmodule

// File: rtl/ext_latch_wm1.sv
// Top: eight-byte display read latch with latch-copy, pass and fill writes,
// plus per-pixel color compare. The wide latch is honoured only when the
// times-eight addressing mode is also selected.
module ext_latch_wm1
    import ext_latch_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int BW     = 8,
    localparam int WB    = 2 * PLANES,
    localparam int LW    = WB * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_en,
    input  logic              x8_addr,
    input  logic              mem_rd_valid,
    input  logic [LW-1:0]     mem_rd_data,
    input  logic              host_wr,
    input  logic [BW-1:0]     host_data,
    input  logic [1:0]        wr_mode,
    input  logic [PLANES-1:0] map_mask,
    input  logic              sr_en,
    input  logic [BW-1:0]     sr_value,
    input  logic [BW-1:0]     cmp_color,
    input  logic [BW-1:0]     cmp_care,
    input  logic [BW-1:0]     fg_color,
    input  logic [BW-1:0]     bg_color,
    input  logic              fg_en,
    input  logic              bg_en,
    output logic              mem_wr_valid,
    output logic [LW-1:0]     mem_wr_data,
    output logic [WB-1:0]     mem_wr_be,
    output logic [WB-1:0]     rd_cmp
);
    logic          wide;
    logic [LW-1:0] latch_q;
    wmode_e        mode;

    // wide latch only counts in the packed addressing mode
    always_comb wide = wide_en && x8_addr;
    // typed view of the mode field
    always_comb mode = wmode_e'(wr_mode);

    elw_latch_bank #(.PLANES(PLANES), .BW(BW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide),
        .rd_valid (mem_rd_valid),
        .rd_data  (mem_rd_data),
        .latch_q  (latch_q)
    );

    elw_compare #(.PLANES(PLANES), .BW(BW)) u_cmp (
        .wide      (wide),
        .latch_q   (latch_q),
        .cmp_color (cmp_color),
        .cmp_care  (cmp_care),
        .match     (rd_cmp)
    );

    elw_write_path #(.PLANES(PLANES), .BW(BW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (wide),
        .host_wr   (host_wr),
        .host_data (host_data),
        .mode      (mode),
        .map_mask  (map_mask),
        .sr_en     (sr_en),
        .sr_value  (sr_value),
        .fg_color  (fg_color),
        .bg_color  (bg_color),
        .fg_en     (fg_en),
        .bg_en     (bg_en),
        .latch_q   (latch_q),
        .wr_valid  (mem_wr_valid),
        .wr_data   (mem_wr_data),
        .wr_be     (mem_wr_be)
    );
endmodule

// File: rtl/elw_checker.sv
// Checker: temporal properties of the extended latch, bound to the top.
module elw_checker #(
    parameter int PLANES = 4,
    parameter int BW     = 8,
    localparam int WB    = 2 * PLANES,
    localparam int LW    = WB * BW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_en,
    input logic              x8_addr,
    input logic              mem_rd_valid,
    input logic              host_wr,
    input logic [1:0]        wr_mode,
    input logic [PLANES-1:0] map_mask,
    input logic [LW-1:0]     latch_q,
    input logic              mem_wr_valid,
    input logic [LW-1:0]     mem_wr_data,
    input logic [WB-1:0]     mem_wr_be,
    input logic [WB-1:0]     rd_cmp
);
    assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_valid |=> $stable(latch_q));

    assert_upper_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !(wide_en && x8_addr))
        |=> latch_q[LW-1:LW/2] == $past(latch_q[LW-1:LW/2]));

    assert_wr_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> mem_wr_valid);

    assert_wr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> (!mem_wr_valid && mem_wr_be == '0));

    assert_copy_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && wr_mode == 2'b01) |=> mem_wr_data == $past(latch_q));

    assert_be_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (mem_wr_be[PLANES-1:0] & ~$past(map_mask)) == '0);

    assert_be_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !(wide_en && x8_addr)) |=> mem_wr_be[WB-1:PLANES] == '0);

    assert_cmp_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wide_en && x8_addr) |-> rd_cmp[WB-1:PLANES] == '0);
endmodule

bind ext_latch_wm1 elw_checker #(.PLANES(PLANES), .BW(BW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_en      (wide_en),
    .x8_addr      (x8_addr),
    .mem_rd_valid (mem_rd_valid),
    .host_wr      (host_wr),
    .wr_mode      (wr_mode),
    .map_mask     (map_mask),
    .latch_q      (latch_q),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_be    (mem_wr_be),
    .rd_cmp       (rd_cmp)
);

// File: tb/test_ext_latch_wm1.sv
// Bench: sweeps the default configuration and predicts outputs arithmetically.
module test_ext_latch_wm1;
    localparam int CLK_PERIOD = 10;
    localparam int PL = 4;
    localparam int B  = 8;
    localparam int NB = 2 * PL;
    localparam int LW = NB * B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wide_en = 0, x8_addr = 0, mem_rd_valid = 0, host_wr = 0;
    logic [LW-1:0] mem_rd_data = '0;
    logic [B-1:0]  host_data = '0;
    logic [1:0]    wr_mode = 2'b00;
    logic [PL-1:0] map_mask = '1;
    logic sr_en = 0, fg_en = 0, bg_en = 0;
    logic [B-1:0] sr_value = '0, cmp_color = '0, cmp_care = '0, fg_color = '0, bg_color = '0;
    logic          mem_wr_valid;
    logic [LW-1:0] mem_wr_data;
    logic [NB-1:0] mem_wr_be;
    logic [NB-1:0] rd_cmp;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [LW-1:0] ml = '0;   // model of latch contents
    logic [LW-1:0] ed;
    logic [NB-1:0] eb;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_latch_wm1 i_ext_latch_wm1 (
        .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .x8_addr(x8_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .host_wr(host_wr), .host_data(host_data), .wr_mode(wr_mode),
        .map_mask(map_mask), .sr_en(sr_en), .sr_value(sr_value),
        .cmp_color(cmp_color), .cmp_care(cmp_care), .fg_color(fg_color),
        .bg_color(bg_color), .fg_en(fg_en), .bg_en(bg_en),
        .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .rd_cmp(rd_cmp));

    function automatic bit is_wide();
        return wide_en && x8_addr;
    endfunction

    task automatic chk(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected compare vector from the model latch (R7, R8)
    function automatic logic [NB-1:0] exp_cmp();
        logic [NB-1:0] r;
        for (int k = 0; k < NB; k++)
            r[k] = (((ml[k*B +: B] ^ cmp_color) & cmp_care) == 0) && (k < PL || is_wide());
        return r;
    endfunction

    // expected write data/enables from current inputs and model latch
    task automatic predict();
        for (int k = 0; k < NB; k++) begin
            logic on;
            on = map_mask[k % PL] && (k < PL || is_wide());
            case (wr_mode)
                2'b01: begin ed[k*B +: B] = ml[k*B +: B]; eb[k] = on; end
                2'b10: begin
                    ed[k*B +: B] = host_data[k % B] ? fg_color : bg_color;
                    eb[k] = on && (host_data[k % B] ? fg_en : bg_en);
                end
                default: begin ed[k*B +: B] = sr_en ? sr_value : host_data; eb[k] = on; end
            endcase
        end
    endtask

    task automatic do_read(logic [LW-1:0] d);
        @(negedge clk);
        mem_rd_valid = 1; mem_rd_data = d;
        @(negedge clk);
        mem_rd_valid = 0;
        if (is_wide()) ml = d; else ml[LW/2-1:0] = d[LW/2-1:0];
    endtask

    task automatic do_write(string req, logic rd_too, logic [LW-1:0] d);
        @(negedge clk);
        predict();
        host_wr = 1;
        mem_rd_valid = rd_too; mem_rd_data = d;
        @(negedge clk);
        host_wr = 0; mem_rd_valid = 0;
        chk({req, " valid"}, LW'(mem_wr_valid), LW'(1'b1));
        chk({req, " data"}, mem_wr_data, ed);
        chk({req, " be"}, LW'(mem_wr_be), LW'(eb));
        if (rd_too) begin
            if (is_wide()) ml = d; else ml[LW/2-1:0] = d[LW/2-1:0];
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 19000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9 reset state, R1 latch zero seen through compare
        chk("R9 valid", LW'(mem_wr_valid), '0);
        chk("R9 data", mem_wr_data, '0);
        chk("R9 be", LW'(mem_wr_be), '0);
        cmp_care = 8'hFF;
        #1 chk("R1 reset latch cmp", LW'(rd_cmp), LW'(exp_cmp()));

        // R1 R2 R7 R8: reads in every wide/addressing combination, all care masks
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            wide_en = w[0]; x8_addr = w[1];
            pat = {8'h5A, 8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h3C, 8'h5A} ^ {8{8'(w * 17)}};
            do_read(pat);
            cmp_color = 8'h3C ^ 8'(w * 17);
            for (int c = 0; c < 256; c++) begin
                cmp_care = 8'(c);
                #1 chk("R7 R8 compare", LW'(rd_cmp), LW'(exp_cmp()));
            end
            // R1 R2 R4: full latch seen through a copy write
            wr_mode = 2'b01; map_mask = 4'hF; host_data = 8'(w * 29);
            do_write("R1 R2 R4 copy", 0, '0);
            // R3 idle cycle after a write
            @(negedge clk);
            chk("R3 idle valid", LW'(mem_wr_valid), '0);
            chk("R3 idle be", LW'(mem_wr_be), '0);
        end

        // R4: copy with a same-cycle read uses the old latch; host byte ignored
        for (int w = 0; w < 4; w++) begin
            wide_en = w[0]; x8_addr = w[1];
            for (int m = 0; m < 16; m++) begin
                wr_mode = 2'b01; map_mask = 4'(m); host_data = 8'(m * 37 + w);
                pat = {16{4'(m + w)}};
                do_write("R4 copy+read", 1, pat);
            end
        end

        // R5: pass modes 00 and 11, set/reset on and off, every host byte
        fg_en = 0; bg_en = 0;
        for (int w = 0; w < 4; w++) begin
            wide_en = w[0]; x8_addr = w[1];
            for (int s = 0; s < 2; s++) begin
                sr_en = s[0]; sr_value = 8'hC3 ^ 8'(w);
                for (int h = 0; h < 256; h++) begin
                    wr_mode = h[0] ? 2'b11 : 2'b00;
                    host_data = 8'(h); map_mask = 4'(h >> 2);
                    do_write("R5 pass", 0, '0);
                end
            end
        end

        // R6 R8: fill sweep over every pixel pattern and enable pair
        wr_mode = 2'b10; fg_color = 8'hE7; bg_color = 8'h18;
        for (int w = 0; w < 4; w++) begin
            wide_en = w[0]; x8_addr = w[1];
            for (int e = 0; e < 4; e++) begin
                fg_en = e[0]; bg_en = e[1];
                for (int h = 0; h < 256; h++) begin
                    host_data = 8'(h); map_mask = 4'(h >> 4) ^ 4'b1010;
                    do_write("R6 fill", 0, '0);
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule